// File: doc/BRIEF.md
# Sixteen-Channel Gated Clock-Enable Composite

This block turns four shared source clock-enable streams, all synchronous to one system clock, into sixteen independent output clock-enable streams. Each output channel picks one of the four sources, divides its pulse rate by a power of two (1, 2, 4 or 8) and can be gated off, in which case its output stays low. The block does not switch clocks and does not choose ratios: it applies exactly the encodings software writes.

All channels are configured through three packed 32-bit registers reached over a simple single-cycle register port addressed by byte offset: one holds the per-channel disable bits, one the per-channel 2-bit source fields, one the per-channel 2-bit divide exponents. The source enables and the outputs are plain level signals sampled and produced on every clock, so there is no valid/ready handshake and no back-pressure: an output pulse is a one-cycle high level that a consumer must take in that cycle, and the source inputs are accepted every cycle. A channel changes its source or ratio only at one of its own output-pulse boundaries, so no short or stretched period appears after reprogramming.

Top module: `clk_channel_bank`

## Requirements
- R1: After reset every disable bit reads 1 (the gate register reads 0x0000FFFF), the select and divider registers read 0, and every output is low.
- R2: With reg_we high at a rising edge, a write to byte offset 0x0 loads the gate register, 0x4 the select register and 0x8 the divider register at that edge; reg_rdata shows the register at reg_addr in the same cycle, and any other offset reads 0 and a write to it changes no register.
- R3: Gate bit i at 1 disables channel i: from the second rising edge after the write edge, ch_out[i] stays low while the bit is 1.
- R4: Bits [2i+1:2i] of the select register pick which src_en bit (index 0 to 3) channel i counts.
- R5: With divider field v in bits [2i+1:2i] of the divider register, an enabled channel produces one output pulse per 2^v cycles in which its selected source is high.
- R6: The output is registered: the pulse appears in the cycle after the rising edge that samples the source high that completes the count, so a channel with ratio 1 on a source that is always high is high every cycle.
- R7: A disabled channel holds its count at zero, so after the gate bit is cleared the first pulse comes after exactly 2^v further source-high cycles.
- R8: A new select or divider field for an enabled channel takes effect at the edge that produces its next output pulse; a disabled channel takes the fields at every edge.
- R9: Gate register bits 31:16 are not stored: they read 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_en | input | 4 | Source clock-enable streams, one per source index |
| reg_we | input | 1 | Register write strobe, one write per cycle it is high |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| ch_out | output | 16 | Output clock-enable stream per channel |

## Verification
A register write lands at the edge where reg_we is sampled and reads back combinationally in the next cycle, while a channel output is due one edge after the source sample that completes its count, and a gate or field change reaches the counter one edge after the register edge. The bench drives every input on the falling edge and keeps a behavioural model that steps on each rising edge with the register values as they stood before that edge, then compares all sixteen outputs on the following falling edge. Directed checks count the exact falling edge after a write at which a pulse must or must not appear, covering ungating latency, gating latency and the deferred ratio change.

// File: rtl/chx_pkg.sv
package chx_pkg;
  // byte offsets of the three control words
  localparam int unsigned OFS_GATE = 32'h0;
  localparam int unsigned OFS_SRC  = 32'h4;
  localparam int unsigned OFS_DIV  = 32'h8;

  typedef enum logic [1:0] {
    RHIT_NONE = 2'd0,
    RHIT_GATE = 2'd1,
    RHIT_SRC  = 2'd2,
    RHIT_DIV  = 2'd3
  } reg_hit_e;
endpackage

// File: rtl/chx_regs.sv
module chx_regs
  import chx_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int FLDW = 2,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [NCH-1:0]      gate_q,
  output logic [NCH*FLDW-1:0] sel_q,
  output logic [NCH*FLDW-1:0] div_q
);
  localparam int PW = NCH * FLDW;
  localparam logic [AW-1:0] A_GATE = AW'(OFS_GATE);
  localparam logic [AW-1:0] A_SRC  = AW'(OFS_SRC);
  localparam logic [AW-1:0] A_DIV  = AW'(OFS_DIV);

  reg_hit_e hit;

  always_comb begin
    unique case (addr)
      A_GATE:  hit = RHIT_GATE;
      A_SRC:   hit = RHIT_SRC;
      A_DIV:   hit = RHIT_DIV;
      default: hit = RHIT_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= '1;
      sel_q  <= '0;
      div_q  <= '0;
    end else if (we) begin
      case (hit)
        RHIT_GATE: gate_q <= wdata[NCH-1:0];
        RHIT_SRC:  sel_q  <= wdata[PW-1:0];
        RHIT_DIV:  div_q  <= wdata[PW-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (hit)
      RHIT_GATE: rdata[NCH-1:0] = gate_q;
      RHIT_SRC:  rdata[PW-1:0]  = sel_q;
      RHIT_DIV:  rdata[PW-1:0]  = div_q;
      default:   rdata = '0;
    endcase
  end

  // R2
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr != A_GATE) && (addr != A_SRC) && (addr != A_DIV))
      |=> ($stable(gate_q) && $stable(sel_q) && $stable(div_q)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(gate_q) && $stable(sel_q) && $stable(div_q)));
endmodule

// File: rtl/chx_channel.sv
module chx_channel #(
  parameter int NSRC = 4,
  parameter int FLDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_en,
  input  logic            gate_off,
  input  logic [FLDW-1:0] sel_cfg,
  input  logic [FLDW-1:0] div_cfg,
  output logic            ch_out
);
  // largest exponent is 2^FLDW-1, so the counter needs that many bits
  localparam int CNTW = (1 << FLDW) - 1;

  logic [FLDW-1:0] act_sel;
  logic [FLDW-1:0] act_div;
  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] last_cnt;
  logic            src_hit;

  always_comb begin
    src_hit = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (int'(act_sel) == s) src_hit = src_en[s];
    end
  end

  assign last_cnt = ~({CNTW{1'b1}} << act_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      ch_out  <= 1'b0;
      act_sel <= '0;
      act_div <= '0;
    end else if (gate_off) begin
      cnt     <= '0;
      ch_out  <= 1'b0;
      act_sel <= sel_cfg;
      act_div <= div_cfg;
    end else if (src_hit) begin
      if (cnt == last_cnt) begin
        cnt     <= '0;
        ch_out  <= 1'b1;
        act_sel <= sel_cfg;
        act_div <= div_cfg;
      end else begin
        cnt    <= cnt + CNTW'(1);
        ch_out <= 1'b0;
      end
    end else begin
      ch_out <= 1'b0;
    end
  end

  // R3
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> !ch_out);

  // R7
  gated_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> (cnt == '0));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_out |-> $past(src_hit));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_off |=> (ch_out || ($stable(act_sel) && $stable(act_div))));
endmodule

// File: rtl/clk_channel_bank.sv
module clk_channel_bank #(
  parameter int NCH  = 16,
  parameter int NSRC = 4,
  parameter int FLDW = 2,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_en,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [NCH-1:0]  ch_out
);
  localparam int PW = NCH * FLDW;

  logic [NCH-1:0] gate_q;
  logic [PW-1:0]  sel_q;
  logic [PW-1:0]  div_q;

  chx_regs #(
    .NCH (NCH),
    .FLDW(FLDW),
    .AW  (AW),
    .DW  (DW)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .gate_q(gate_q),
    .sel_q (sel_q),
    .div_q (div_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chx_channel #(
      .NSRC(NSRC),
      .FLDW(FLDW)
    ) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_en  (src_en),
      .gate_off(gate_q[g]),
      .sel_cfg (sel_q[g*FLDW +: FLDW]),
      .div_cfg (div_q[g*FLDW +: FLDW]),
      .ch_out  (ch_out[g])
    );
  end

  // R3
  all_gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&gate_q) |=> (ch_out == '0));
endmodule

// File: tb/clk_channel_bank_bench.sv
`timescale 1ns/1ps
module clk_channel_bank_bench;
  localparam int NCH = 16;
  localparam int NSRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_en = 4'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [15:0] ch_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  clk_channel_bank u_clk_channel_bank (
    .clk(clk), .rst_n(rst_n), .src_en(src_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ch_out(ch_out)
  );

  // source pattern: 0 always high, 1 toggles, 2 every third cycle, 3 pseudo-random
  int unsigned ph = 0;
  logic [7:0] lfsr = 8'h5A;
  always @(negedge clk) begin
    ph++;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    src_en <= {lfsr[0], (ph % 3) == 0, ph[0], 1'b1};
  end

  // behavioural reference, stepped with pre-edge values
  logic [15:0] m_gate;
  logic [31:0] m_sel, m_div;
  int          m_cnt [NCH];
  int          m_asel [NCH];
  int          m_adiv [NCH];
  logic [15:0] m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate = 16'hFFFF; m_sel = '0; m_div = '0; m_out = '0;
      for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_asel[c] = 0; m_adiv[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (m_gate[c]) begin
          m_cnt[c] = 0; m_out[c] = 1'b0;
          m_asel[c] = int'(m_sel[2*c +: 2]); m_adiv[c] = int'(m_div[2*c +: 2]);
        end else if (src_en[m_asel[c]]) begin
          m_cnt[c] = m_cnt[c] + 1;
          if (m_cnt[c] == (1 << m_adiv[c])) begin
            m_cnt[c] = 0; m_out[c] = 1'b1;
            m_asel[c] = int'(m_sel[2*c +: 2]); m_adiv[c] = int'(m_div[2*c +: 2]);
          end else m_out[c] = 1'b0;
        end else m_out[c] = 1'b0;
      end
      if (reg_we) begin
        case (reg_addr)
          8'h00: m_gate = reg_wdata[15:0];
          8'h04: m_sel = reg_wdata;
          8'h08: m_div = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison of all outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (ch_out !== m_out) begin
        bad++;
        $display("FAIL %s per-clock outputs: actual=%h expected=%h", phase, ch_out, m_out);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [31:0] setf(input logic [31:0] v, input int c, input logic [1:0] f);
    logic [31:0] r = v;
    r[2*c +: 2] = f;
    return r;
  endfunction

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(20 * 50000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] gsh;
    logic [31:0] ssh, dsh;
    int n0, n1, n2, n5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    phase = "R1";
    chk("R1 outputs low", {16'h0, ch_out}, 32'h0);
    rd(8'h00, 32'h0000FFFF, "R1 gate reset");
    rd(8'h04, 32'h0, "R1 select reset");
    rd(8'h08, 32'h0, "R1 divider reset");

    // R2 program select and divider
    phase = "R2";
    ssh = 32'h0;
    ssh = setf(ssh, 2, 2'd1); ssh = setf(ssh, 5, 2'd2);
    ssh = setf(ssh, 6, 2'd3); ssh = setf(ssh, 7, 2'd1);
    dsh = 32'h0;
    dsh = setf(dsh, 0, 2'd3); dsh = setf(dsh, 2, 2'd1); dsh = setf(dsh, 3, 2'd2);
    dsh = setf(dsh, 4, 2'd3); dsh = setf(dsh, 6, 2'd1); dsh = setf(dsh, 7, 2'd2);
    @(negedge clk);
    wr(8'h04, ssh);
    wr(8'h08, dsh);
    rd(8'h04, ssh, "R2 select readback");
    rd(8'h08, dsh, "R2 divider readback");

    // ungate channels 0,1,2,5,6,7
    phase = "R5";
    @(negedge clk);
    gsh = 16'hFFFF & ~16'h00E7;
    wr(8'h00, {16'h0, gsh});
    repeat (20) @(negedge clk);
    n0 = 0; n1 = 0; n2 = 0; n5 = 0;
    for (int k = 0; k < 48; k++) begin
      n0 += ch_out[0]; n1 += ch_out[1]; n2 += ch_out[2]; n5 += ch_out[5];
      @(negedge clk);
    end
    chk("R5 ch0 ratio 8 on always-high source", n0, 6);
    chk("R6 ch1 ratio 1 high every cycle", n1, 48);
    chk("R4 ch2 picks toggling source 1, ratio 2", n2, 12);
    chk("R4 ch5 picks every-third source 2, ratio 1", n5, 16);

    // R7 ungate ch3 (ratio 4, source 0): pulse after exactly 4 source highs
    phase = "R7";
    gsh[3] = 1'b0;
    wr(8'h00, {16'h0, gsh});
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 ch3 no pulse before count completes", {31'h0, ch_out[3]}, 32'h0);
    end
    @(negedge clk);
    chk("R7 ch3 first pulse after ungate", {31'h0, ch_out[3]}, 32'h1);

    // R8 ungate ch4 at ratio 8, change to ratio 1 mid-period
    phase = "R8";
    gsh[4] = 1'b0;
    wr(8'h00, {16'h0, gsh});
    repeat (2) @(negedge clk);
    dsh = setf(dsh, 4, 2'd0);
    wr(8'h08, dsh);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 ch4 keeps old ratio until boundary", {31'h0, ch_out[4]}, 32'h0);
    end
    @(negedge clk);
    chk("R8 ch4 pulse at old-ratio boundary", {31'h0, ch_out[4]}, 32'h1);
    @(negedge clk);
    chk("R8 ch4 new ratio after boundary", {31'h0, ch_out[4]}, 32'h1);

    // R4 move ch6 to source 0 while running (model compares each clock)
    phase = "R4";
    ssh = setf(ssh, 6, 2'd0);
    wr(8'h04, ssh);
    repeat (20) @(negedge clk);

    // R3 gate ch1 which pulses every cycle
    phase = "R3";
    gsh[1] = 1'b1;
    wr(8'h00, {16'h0, gsh});
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R3 gated ch1 stays low", {31'h0, ch_out[1]}, 32'h0);
    end

    // R9 upper gate bits not stored
    phase = "R9";
    wr(8'h00, {16'hFFFF, gsh});
    rd(8'h00, {16'h0, gsh}, "R9 gate upper bits read zero");

    // R2 unmapped offsets
    phase = "R2";
    @(negedge clk);
    wr(8'h0C, 32'hFFFFFFFF);
    rd(8'h0C, 32'h0, "R2 unmapped read zero");
    rd(8'h02, 32'h0, "R2 misaligned read zero");
    rd(8'h00, {16'h0, gsh}, "R2 gate unchanged by unmapped write");
    rd(8'h04, ssh, "R2 select unchanged by unmapped write");
    rd(8'h08, dsh, "R2 divider unchanged by unmapped write");

    // mixed traffic with reprogramming, checked per clock
    phase = "R5";
    @(negedge clk);
    dsh = 32'h1B1B_E4E4;
    wr(8'h08, dsh);
    ssh = 32'h9C63_36C9;
    wr(8'h04, ssh);
    gsh = 16'h0F0F;
    wr(8'h00, {16'h0, gsh});
    repeat (100) @(negedge clk);

    summary();
    $finish;
  end
endmodule